// File: doc/BRIEF.md
# Guarded Core Clock Source Register

This block holds one byte of clock configuration. It decides which oscillator or derived clock feeds the core's clock prescaler. The configuration is protected against stray writes. Software first writes a key value that opens a short timed window. Only writes that arrive while that window is open may change the configuration fields. A write to the prescaler register closes the window early.

The block drives a registered 3-bit source code to a downstream glitch-free clock multiplexer. That code changes only on the clock edge that commits a new configuration. While the source-select bit is clear, the fast RC oscillator is always chosen. While it is set, the mode field is locked, so the active source cannot be switched directly to another non-default source. An external-clock-failure pulse forces the select bit low, which returns the core to the fast RC oscillator.

The block also raises a stop request for the slow RC oscillator. It does so only when software has asked for the stop and nothing else needs that clock.

Top module: `clksel_guard`

## Requirements
- R1: After reset the readback is 0x00, `src_sel` is the fast RC code 0 and `slowrc_stop` is 0.
- R2: A write of exactly 0x80 sets readback bit 7 (the window bit) on the next edge. The bit then stays 1 for exactly 4 cycles and clears by itself.
- R3: Bits 6..0 change only through a write made while bit 7 is already 1. A write made while bit 7 is 0 is ignored, and the key write itself changes no other bit.
- R4: Writing the key 0x80 again while the window is open neither restarts the 4-cycle count nor clears bit 7.
- R5: While select bit 3 is 1, mode bits 2:0 cannot change. A write that clears bit 3 also leaves the mode unchanged.
- R6: While bit 3 is 0, the mode field takes the written value. Bit 3 becomes 1 only if the written mode equals the current mode; otherwise bit 3 stays 0 and only the mode is updated.
- R7: `src_sel` codes are: 0 fast RC (whenever bit 3 is 0). With bit 3 set, mode 000 gives 1 (slow RC), 001 gives 2 (divided clock), 010 gives 3 (external), 011 gives 4 (crystal/6), and 100 to 111 give 5 (crystal/4).
- R8: A pulse on `psc_wr` clears bit 7 on the next edge. Field writes that follow it are ignored.
- R9: A pulse on `ext_fail` clears bit 3 on the next edge. This takes priority over a simultaneous accepted write that tries to set bit 3.
- R10: `slowrc_stop` is 1 only when stored bit 4 is 1, `wdt_fuse_on` is 0, `wdt_enabled` is 0 and `slowrc_users` is 0. It is registered, so it follows these conditions one edge later.
- R11: Bit 6 (monitor enable) and bit 4 (slow RC stop request) store the written value. Bit 5 always reads 0.
- R12: `reg_q` and `src_sel` reflect an accepted write on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Decoded write strobe for this register |
| wr_data | input | 8 | Write data |
| psc_wr | input | 1 | Prescaler register write strobe |
| ext_fail | input | 1 | External clock failure pulse |
| wdt_fuse_on | input | 1 | Watchdog-always-on fuse |
| wdt_enabled | input | 1 | Watchdog currently enabled |
| slowrc_users | input | 1 | Another module needs the slow RC clock |
| reg_q | output | 8 | Register readback |
| src_sel | output | 3 | Registered clock source code |
| slowrc_stop | output | 1 | Slow RC oscillator stop request |

## Verification
The bench builds the block with the default window length of 4 cycles. At that length, every cycle of a window can be scored one by one: opening, a repeated key that must not extend it, the natural expiry, and the early close by a prescaler write. This short window also leaves room for several unlock sequences. Across them the bench walks the select bit through its refusal case, the frozen-mode case and the failure fallback, including the collision of a failure with a write.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int REG_W    = 8;
  localparam int MODE_W   = 3;
  localparam int WIN_BIT  = 7;
  localparam int MON_BIT  = 6;
  localparam int RSV_BIT  = 5;
  localparam int SRCD_BIT = 4;
  localparam int SEL_BIT  = 3;

  typedef enum logic [2:0] {
    SRC_FAST_RC   = 3'd0,
    SRC_SLOW_RC   = 3'd1,
    SRC_DIVIDED   = 3'd2,
    SRC_EXTERNAL  = 3'd3,
    SRC_XTAL_DIV6 = 3'd4,
    SRC_XTAL_DIV4 = 3'd5
  } clk_src_e;

  typedef struct packed {
    logic              mon;
    logic              srcd;
    logic              sel;
    logic [MODE_W-1:0] mode;
  } cfg_t;
endpackage

// File: rtl/clksel_unlock.sv
module clksel_unlock #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic kill,
  output logic open
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open   <= 1'b0;
      left_q <= '0;
    end else if (kill) begin
      open   <= 1'b0;
      left_q <= '0;
    end else if (open) begin
      if (left_q == '0) open <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (arm) begin
      open   <= 1'b1;
      left_q <= CNT_W'(CYCLES - 1);
    end
  end
endmodule

// File: rtl/clksel_cfg.sv
module clksel_cfg
  import clksel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_ok,
  input  cfg_t wr_cfg,
  input  logic fail,
  output cfg_t cfg_d,
  output cfg_t cfg_q
);
  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      cfg_d.mon  = wr_cfg.mon;
      cfg_d.srcd = wr_cfg.srcd;
      if (!cfg_q.sel) begin
        // mode free; select may rise only if mode is unchanged
        cfg_d.mode = wr_cfg.mode;
        cfg_d.sel  = wr_cfg.sel && (wr_cfg.mode == cfg_q.mode);
      end else begin
        cfg_d.sel = wr_cfg.sel;
      end
    end
    if (fail) cfg_d.sel = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/clksel_srcmap.sv
module clksel_srcmap
  import clksel_pkg::*;
(
  input  logic              sel,
  input  logic [MODE_W-1:0] mode,
  output clk_src_e          src
);
  always_comb begin
    if (!sel) begin
      src = SRC_FAST_RC;
    end else begin
      case (mode)
        3'd0:    src = SRC_SLOW_RC;
        3'd1:    src = SRC_DIVIDED;
        3'd2:    src = SRC_EXTERNAL;
        3'd3:    src = SRC_XTAL_DIV6;
        default: src = SRC_XTAL_DIV4;
      endcase
    end
  end
endmodule

// File: rtl/clksel_guard.sv
module clksel_guard
  import clksel_pkg::*;
#(
  parameter int          UNLOCK_CYCLES = 4,
  parameter logic [7:0]  UNLOCK_KEY    = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       psc_wr,
  input  logic       ext_fail,
  input  logic       wdt_fuse_on,
  input  logic       wdt_enabled,
  input  logic       slowrc_users,
  output logic [7:0] reg_q,
  output logic [2:0] src_sel,
  output logic       slowrc_stop
);
  logic     key_wr, win_open, field_wr;
  cfg_t     wr_cfg, cfg_d, cfg_q;
  clk_src_e src_d;

  assign key_wr   = wr_en && (wr_data == UNLOCK_KEY);
  assign field_wr = wr_en && win_open && !key_wr;
  assign wr_cfg   = '{mon:  wr_data[MON_BIT],
                      srcd: wr_data[SRCD_BIT],
                      sel:  wr_data[SEL_BIT],
                      mode: wr_data[MODE_W-1:0]};

  clksel_unlock #(.CYCLES(UNLOCK_CYCLES)) u_unlock (
    .clk (clk),
    .rst (rst),
    .arm (key_wr),
    .kill(psc_wr),
    .open(win_open)
  );

  clksel_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_ok (field_wr),
    .wr_cfg(wr_cfg),
    .fail  (ext_fail),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  clksel_srcmap u_map (
    .sel (cfg_d.sel),
    .mode(cfg_d.mode),
    .src (src_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel     <= SRC_FAST_RC;
      slowrc_stop <= 1'b0;
    end else begin
      src_sel     <= src_d;
      slowrc_stop <= cfg_d.srcd && !wdt_fuse_on && !wdt_enabled && !slowrc_users;
    end
  end

  assign reg_q = {win_open, cfg_q.mon, 1'b0, cfg_q.srcd, cfg_q.sel, cfg_q.mode};
endmodule

// File: rtl/clksel_guard_chk.sv
module clksel_guard_chk #(
  parameter int UNLOCK_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       psc_wr,
  input logic       ext_fail,
  input logic [7:0] reg_q,
  input logic [2:0] src_sel,
  input logic       slowrc_stop
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                hi_run <= '0;
    else if (!reg_q[7])     hi_run <= '0;
    else if (hi_run != '1)  hi_run <= hi_run + 1'b1;
  end

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    32'(hi_run) <= UNLOCK_CYCLES); // R2
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!reg_q[7] && !ext_fail) |=> $stable(reg_q[6:0])); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    reg_q[3] |=> $stable(reg_q[2:0])); // R5
  AST_SEL_RISE_SAME_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_q[3]) |-> $stable(reg_q[2:0])); // R6
  AST_FAST_RC_CODE: assert property (@(posedge clk) disable iff (rst)
    !reg_q[3] |-> (src_sel == 3'd0)); // R7
  AST_PSC_CLOSE: assert property (@(posedge clk) disable iff (rst)
    psc_wr |=> !reg_q[7]); // R8
  AST_FAIL_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    ext_fail |=> !reg_q[3]); // R9
  AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    slowrc_stop |-> reg_q[4]); // R10
endmodule

bind clksel_guard clksel_guard_chk #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .psc_wr     (psc_wr),
  .ext_fail   (ext_fail),
  .reg_q      (reg_q),
  .src_sel    (src_sel),
  .slowrc_stop(slowrc_stop)
);

// File: tb/clksel_guard_tb.sv
module clksel_guard_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       psc_wr = 1'b0;
  logic       ext_fail = 1'b0;
  logic       wdt_fuse_on = 1'b0;
  logic       wdt_enabled = 1'b0;
  logic       slowrc_users = 1'b0;
  logic [7:0] reg_q;
  logic [2:0] src_sel;
  logic       slowrc_stop;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [7:0] er;
    logic [2:0] es;
    logic       est;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  clksel_guard u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .psc_wr(psc_wr), .ext_fail(ext_fail), .wdt_fuse_on(wdt_fuse_on),
    .wdt_enabled(wdt_enabled), .slowrc_users(slowrc_users),
    .reg_q(reg_q), .src_sel(src_sel), .slowrc_stop(slowrc_stop)
  );

  // monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      n_tests++;
      if (reg_q !== it.er || src_sel !== it.es || slowrc_stop !== it.est) begin
        n_fail++;
        $display("FAIL %s: reg=%h src=%0d stop=%b expected reg=%h src=%0d stop=%b",
                 it.tag, reg_q, src_sel, slowrc_stop, it.er, it.es, it.est);
      end
    end
  end

  // driver: one cycle of stimulus, push expected state after the edge
  task automatic cyc(input logic w, input logic [7:0] d, input logic p, input logic f,
                     input logic [7:0] er, input logic [2:0] es, input logic est,
                     input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = w; wr_data = d; psc_wr = p; ext_fail = f;
    @(posedge clk);
    #1;
    it.er = er; it.es = es; it.est = est; it.tag = tag;
    sb.push_back(it);
    wr_en = 1'b0; psc_wr = 1'b0; ext_fail = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc(0, 8'h00, 0, 0, 8'h00, 0, 0, "R1 reset state");
    cyc(1, 8'h45, 0, 0, 8'h00, 0, 0, "R3 locked write ignored");
    cyc(1, 8'h80, 0, 0, 8'h80, 0, 0, "R2 key opens window");
    cyc(1, 8'h02, 0, 0, 8'h82, 0, 0, "R3 mode write, fast RC kept R7");
    cyc(1, 8'h0A, 0, 0, 8'h8A, 3, 0, "R12 select external R7");
    cyc(0, 8'h00, 0, 0, 8'h8A, 3, 0, "R2 window fourth cycle");
    cyc(0, 8'h00, 0, 0, 8'h0A, 3, 0, "R2 window expired");
    cyc(1, 8'h08, 0, 0, 8'h0A, 3, 0, "R3 write after expiry ignored");
    cyc(1, 8'h80, 0, 0, 8'h8A, 3, 0, "R2 reopen");
    cyc(1, 8'h80, 0, 0, 8'h8A, 3, 0, "R4 repeated key");
    cyc(0, 8'h00, 0, 0, 8'h8A, 3, 0, "R4 window third cycle");
    cyc(0, 8'h00, 0, 0, 8'h8A, 3, 0, "R4 window fourth cycle");
    cyc(0, 8'h00, 0, 0, 8'h0A, 3, 0, "R4 not extended");
    cyc(1, 8'h80, 0, 0, 8'h8A, 3, 0, "R2 reopen");
    cyc(1, 8'h0C, 0, 0, 8'h8A, 3, 0, "R5 mode frozen while selected");
    cyc(1, 8'h01, 0, 0, 8'h82, 0, 0, "R5 deselect keeps mode");
    cyc(1, 8'h0B, 0, 0, 8'h83, 0, 0, "R6 select refused on mode change");
    cyc(0, 8'h00, 0, 0, 8'h03, 0, 0, "R2 expiry");
    cyc(1, 8'h80, 0, 0, 8'h83, 0, 0, "R2 reopen");
    cyc(0, 8'h00, 1, 0, 8'h03, 0, 0, "R8 prescaler write closes window");
    cyc(1, 8'h0B, 0, 0, 8'h03, 0, 0, "R8 write after close ignored");
    cyc(1, 8'h80, 0, 0, 8'h83, 0, 0, "R2 reopen");
    cyc(1, 8'h0B, 0, 0, 8'h8B, 4, 0, "R7 crystal/6");
    cyc(0, 8'h00, 0, 1, 8'h83, 0, 0, "R9 failure fallback");
    cyc(1, 8'h0B, 0, 1, 8'h83, 0, 0, "R9 failure beats select write");
    cyc(0, 8'h00, 0, 0, 8'h03, 0, 0, "R2 expiry");
    cyc(1, 8'h80, 0, 0, 8'h83, 0, 0, "R2 reopen");
    cyc(1, 8'h00, 0, 0, 8'h80, 0, 0, "R6 mode free while deselected");
    cyc(1, 8'h08, 0, 0, 8'h88, 1, 0, "R7 slow RC");
    cyc(0, 8'h00, 0, 0, 8'h88, 1, 0, "R2 window fourth cycle");
    cyc(0, 8'h00, 0, 0, 8'h08, 1, 0, "R2 expiry");
    cyc(1, 8'h80, 0, 0, 8'h88, 1, 0, "R2 reopen");
    cyc(1, 8'h07, 0, 0, 8'h80, 0, 0, "R5 deselect ignores mode");
    cyc(1, 8'h0F, 0, 0, 8'h87, 0, 0, "R6 refused, mode updated");
    cyc(1, 8'h0F, 0, 0, 8'h8F, 5, 0, "R7 crystal/4 from mode 7");
    cyc(0, 8'h00, 0, 0, 8'h0F, 5, 0, "R2 expiry");
    cyc(1, 8'h80, 0, 0, 8'h8F, 5, 0, "R2 reopen");
    cyc(1, 8'h7F, 0, 0, 8'hDF, 5, 1, "R11 bit5 reads 0, R10 stop");
    wdt_enabled = 1'b1;
    cyc(0, 8'h00, 0, 0, 8'hDF, 5, 0, "R10 watchdog enabled");
    wdt_enabled = 1'b0; slowrc_users = 1'b1;
    cyc(0, 8'h00, 0, 0, 8'hDF, 5, 0, "R10 other user");
    slowrc_users = 1'b0; wdt_fuse_on = 1'b1;
    cyc(0, 8'h00, 0, 0, 8'h5F, 5, 0, "R10 fuse set");
    wdt_fuse_on = 1'b0;
    cyc(0, 8'h00, 0, 0, 8'h5F, 5, 1, "R10 stop granted, R11 monitor held");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule